// File: doc/BRIEF.md
# Lockable Translation Lookaside Buffer

This block caches address translations for a device-side memory management unit. It holds a configurable number of fully associative entries. Each entry pairs a virtual tag with a page-size code and a valid flag, and carries a physical page base with attribute bits. A lookup port takes a device address and, one cycle later, returns whether a cached entry covers it, the translated physical address and that entry's page size. Four page sizes are supported: 4 KB, 64 KB, 1 MB and 16 MB.

Software manages the array through single-cycle commands: load an entry, flush one entry, flush the whole array, read one entry back, and write the lock register. The lock register has two counters. `lock_base` splits the array into a pinned region below it and a replaceable region above it. `lock_victim` points at the slot that flush-one and read-back act on. A load can be marked as pinned. A pinned load goes into the slot at the base and moves the base up by one. An ordinary load fills the lowest free slot, and the victim pointer then advances past that slot. When the pointer reaches the entry count it wraps to the base, not to zero. A load that cannot be placed is refused with a one-cycle busy pulse.

Top module: `xlat_tlb`

## Requirements
- R1: After synchronous reset, `lock_base` and `lock_victim` are 0, every entry is invalid with all fields zero, and `cmd_busy`, `rd_valid` and `lk_done` are low.
- R2: An accepted ordinary load (op 0, `cmd_preserve`=0) writes the lowest-index invalid slot and marks it valid. Afterwards `lock_victim` is that slot plus one, or `lock_base` when slot plus one equals the entry count. `lock_base` is unchanged.
- R3: An accepted pinned load (op 0, `cmd_preserve`=1) writes the slot equal to `lock_base`, whether that slot is valid or not. Both `lock_base` and `lock_victim` then become the old base plus one.
- R4: When `lock_base` equals the entry count, every load (op 0) is refused. `cmd_busy` is high in the following cycle, and no entry, base or victim changes.
- R5: An ordinary load is refused with `cmd_busy` when every slot is valid, leaving the state unchanged. A pinned load is still accepted in that case if `lock_base` is below the entry count.
- R6: The page-size code in CAM bits [1:0] is 0 for 1 MB, 1 for 64 KB, 2 for 4 KB and 3 for 16 MB. An entry covers an address when both agree on every address bit at or above the page size. The physical address is the physical base above the page size, joined with the address below it.
- R7: `lk_done` is high exactly in the cycle after `lk_valid` was high. When several valid entries cover the address, the lowest-index one is reported. On a miss, `lk_hit`, `lk_paddr` and `lk_size` are zero.
- R8: Flush-one (op 1) clears the valid flag of the slot at `lock_victim` and changes neither counter. It has no effect when `lock_victim` equals the entry count.
- R9: Lock write (op 4) loads `lock_base` from `cmd_base` and `lock_victim` from `cmd_victim`, each clamped to the entry count. Read (op 3) raises `rd_valid` for one cycle, the cycle after the command. It returns the slot at `lock_victim` as two words. The CAM word holds the tag in [31:12], zeros in [11:3], the valid flag in [2] and the size in [1:0]. The RAM word holds the physical base in [31:12] and the attributes in [11:0]. Both words are zero when `lock_victim` equals the entry count.
- R10: Flush-all (op 2) invalidates every entry and sets both `lock_base` and `lock_victim` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command strobe, one cycle per command |
| cmd_op | input | 3 | 0 load, 1 flush one, 2 flush all, 3 read, 4 lock write; others ignored |
| cmd_cam | input | 32 | Load: tag [31:12], size code [1:0] |
| cmd_ram | input | 32 | Load: physical base [31:12], attributes [11:0] |
| cmd_preserve | input | 1 | Load goes into the pinned region |
| cmd_base | input | CNT_W | Lock write: new base value |
| cmd_victim | input | CNT_W | Lock write: new victim value |
| cmd_busy | output | 1 | Pulse: the previous load was refused |
| rd_valid | output | 1 | Pulse: read-back words are fresh |
| rd_cam | output | 32 | Read-back CAM word |
| rd_ram | output | 32 | Read-back RAM word |
| lock_base | output | CNT_W | Count of pinned entries |
| lock_victim | output | CNT_W | Slot pointer for flush-one and read |
| lk_valid | input | 1 | Lookup request |
| lk_addr | input | 32 | Device address to translate |
| lk_done | output | 1 | Lookup result is valid |
| lk_hit | output | 1 | An entry covered the address |
| lk_paddr | output | 32 | Translated physical address |
| lk_size | output | 2 | Size code of the matching entry |

## Verification
The bench sweeps each page size across the edges of its region: the byte before the start, the first byte, the middle, the last byte and the first byte past the end. A mask off by one nibble, or with a size code mapped to the wrong span, misses or over-matches at one of these edges. It drives the victim pointer to the entry count after filling the top slot. If the wrap went to zero rather than to the base, the pinned slot would later be overwritten or flushed, and the victim readback would be wrong. Overlapping entries of different sizes check the lowest-index priority; an encoder that prefers high indexes returns the wrong physical base. Loads are also issued against a full array and a fully pinned array, and clamped lock writes are checked. A design that ignored the full condition would silently replace a valid or pinned translation.

// File: rtl/xlat_tlb_pkg.sv
package xlat_tlb_pkg;

    localparam int ADDR_W   = 32;
    localparam int PAGE_LSB = 12;
    localparam int TAG_W    = ADDR_W - PAGE_LSB;
    localparam int ATTR_W   = PAGE_LSB;

    typedef enum logic [1:0] {
        PG_1M  = 2'd0,
        PG_64K = 2'd1,
        PG_4K  = 2'd2,
        PG_16M = 2'd3
    } pgsz_e;

    typedef enum logic [2:0] {
        OP_LOAD      = 3'd0,
        OP_FLUSH_ONE = 3'd1,
        OP_FLUSH_ALL = 3'd2,
        OP_READ      = 3'd3,
        OP_LOCK_WR   = 3'd4
    } op_e;

    typedef struct packed {
        logic              vld;
        logic [TAG_W-1:0]  vtag;
        pgsz_e             sz;
        logic [TAG_W-1:0]  pbase;
        logic [ATTR_W-1:0] attr;
    } entry_t;

    // Mask over the page-number bits that take part in the tag compare.
    function automatic logic [TAG_W-1:0] tag_mask(pgsz_e sz);
        logic [TAG_W-1:0] m;
        case (sz)
            PG_4K:   m = {TAG_W{1'b1}};
            PG_64K:  m = {{(TAG_W-4){1'b1}}, 4'h0};
            PG_1M:   m = {{(TAG_W-8){1'b1}}, 8'h0};
            default: m = {{(TAG_W-12){1'b1}}, 12'h0};
        endcase
        return m;
    endfunction

    function automatic entry_t make_entry(logic [ADDR_W-1:0] cam, logic [ADDR_W-1:0] ram);
        entry_t e;
        e.vld   = 1'b1;
        e.vtag  = cam[ADDR_W-1:PAGE_LSB];
        e.sz    = pgsz_e'(cam[1:0]);
        e.pbase = ram[ADDR_W-1:PAGE_LSB];
        e.attr  = ram[ATTR_W-1:0];
        return e;
    endfunction

    function automatic logic [ADDR_W-1:0] cam_word(entry_t e);
        return {e.vtag, {(PAGE_LSB-3){1'b0}}, e.vld, e.sz};
    endfunction

    function automatic logic [ADDR_W-1:0] ram_word(entry_t e);
        return {e.pbase, e.attr};
    endfunction

endpackage

// File: rtl/xlat_tlb_lock.sv
module xlat_tlb_lock
    #(parameter int NUM_ENTRIES = 8,
      parameter int CNT_W       = $clog2(NUM_ENTRIES + 1))
    (
    input  logic             clk,
    input  logic             rst,
    input  logic             do_flush_all,
    input  logic             do_lock_wr,
    input  logic [CNT_W-1:0] wr_base,
    input  logic [CNT_W-1:0] wr_victim,
    input  logic             do_pin,
    input  logic             do_norm,
    input  logic [CNT_W-1:0] norm_slot,
    output logic [CNT_W-1:0] base_q,
    output logic [CNT_W-1:0] victim_q
    );

    localparam logic [CNT_W-1:0] FULL = CNT_W'(NUM_ENTRIES);

    function automatic logic [CNT_W-1:0] clamp(logic [CNT_W-1:0] v);
        return (v > FULL) ? FULL : v;
    endfunction

    logic [CNT_W-1:0] after_slot;
    logic [CNT_W-1:0] base_inc;

    assign after_slot = CNT_W'(norm_slot + 1'b1);
    assign base_inc   = CNT_W'(base_q + 1'b1);

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q   <= '0;
            victim_q <= '0;
        end else if (do_flush_all) begin
            base_q   <= '0;
            victim_q <= '0;
        end else if (do_lock_wr) begin
            base_q   <= clamp(wr_base);
            victim_q <= clamp(wr_victim);
        end else if (do_pin) begin
            base_q   <= base_inc;
            victim_q <= base_inc;
        end else if (do_norm) begin
            victim_q <= (after_slot == FULL) ? base_q : after_slot;
        end
    end

endmodule

// File: rtl/xlat_tlb_free.sv
module xlat_tlb_free
    #(parameter int NUM_ENTRIES = 8,
      parameter int CNT_W       = $clog2(NUM_ENTRIES + 1))
    (
    input  logic [NUM_ENTRIES-1:0] vld,
    output logic                   any_free,
    output logic [CNT_W-1:0]       free_idx
    );

    always_comb begin
        any_free = 1'b0;
        free_idx = '0;
        for (int i = NUM_ENTRIES - 1; i >= 0; i--) begin
            if (!vld[i]) begin
                any_free = 1'b1;
                free_idx = CNT_W'(i);
            end
        end
    end

endmodule

// File: rtl/xlat_tlb_match.sv
module xlat_tlb_match
    import xlat_tlb_pkg::*;
    #(parameter int NUM_ENTRIES = 8)
    (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         lk_valid,
    input  logic [ADDR_W-1:0]            lk_addr,
    input  entry_t [NUM_ENTRIES-1:0]     ents,
    output logic                         lk_done,
    output logic                         lk_hit,
    output logic [ADDR_W-1:0]            lk_paddr,
    output logic [1:0]                   lk_size
    );

    logic [NUM_ENTRIES-1:0]  hits;
    logic [ADDR_W-1:0]       pa_vec [NUM_ENTRIES];
    logic [TAG_W-1:0]        vpn;

    assign vpn = lk_addr[ADDR_W-1:PAGE_LSB];

    for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_cmp
        logic [TAG_W-1:0] m;
        assign m         = tag_mask(ents[g].sz);
        assign hits[g]   = ents[g].vld && ((vpn & m) == (ents[g].vtag & m));
        assign pa_vec[g] = {(ents[g].pbase & m) | (vpn & ~m), lk_addr[PAGE_LSB-1:0]};
    end

    logic              sel_hit;
    logic [ADDR_W-1:0] sel_pa;
    logic [1:0]        sel_sz;

    always_comb begin
        sel_hit = 1'b0;
        sel_pa  = '0;
        sel_sz  = '0;
        for (int i = NUM_ENTRIES - 1; i >= 0; i--) begin
            if (hits[i]) begin
                sel_hit = 1'b1;
                sel_pa  = pa_vec[i];
                sel_sz  = ents[i].sz;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lk_done  <= 1'b0;
            lk_hit   <= 1'b0;
            lk_paddr <= '0;
            lk_size  <= '0;
        end else begin
            lk_done  <= lk_valid;
            lk_hit   <= lk_valid && sel_hit;
            lk_paddr <= lk_valid ? sel_pa : '0;
            lk_size  <= lk_valid ? sel_sz : '0;
        end
    end

endmodule

// File: rtl/xlat_tlb.sv
module xlat_tlb
    import xlat_tlb_pkg::*;
    #(parameter int NUM_ENTRIES = 8,
      localparam int CNT_W      = $clog2(NUM_ENTRIES + 1))
    (
    input  logic             clk,
    input  logic             rst,
    input  logic             cmd_valid,
    input  logic [2:0]       cmd_op,
    input  logic [31:0]      cmd_cam,
    input  logic [31:0]      cmd_ram,
    input  logic             cmd_preserve,
    input  logic [CNT_W-1:0] cmd_base,
    input  logic [CNT_W-1:0] cmd_victim,
    output logic             cmd_busy,
    output logic             rd_valid,
    output logic [31:0]      rd_cam,
    output logic [31:0]      rd_ram,
    output logic [CNT_W-1:0] lock_base,
    output logic [CNT_W-1:0] lock_victim,
    input  logic             lk_valid,
    input  logic [31:0]      lk_addr,
    output logic             lk_done,
    output logic             lk_hit,
    output logic [31:0]      lk_paddr,
    output logic [1:0]       lk_size
    );

    localparam logic [CNT_W-1:0] FULL = CNT_W'(NUM_ENTRIES);

    entry_t [NUM_ENTRIES-1:0] ent_q;
    logic   [NUM_ENTRIES-1:0] vld_vec;

    for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_vld
        assign vld_vec[g] = ent_q[g].vld;
    end

    // Command decode
    logic is_load, is_flush_one, is_flush_all, is_read, is_lock_wr;
    assign is_load      = cmd_valid && (cmd_op == OP_LOAD);
    assign is_flush_one = cmd_valid && (cmd_op == OP_FLUSH_ONE);
    assign is_flush_all = cmd_valid && (cmd_op == OP_FLUSH_ALL);
    assign is_read      = cmd_valid && (cmd_op == OP_READ);
    assign is_lock_wr   = cmd_valid && (cmd_op == OP_LOCK_WR);

    logic             any_free;
    logic [CNT_W-1:0] free_idx;

    xlat_tlb_free #(.NUM_ENTRIES(NUM_ENTRIES), .CNT_W(CNT_W)) u_free (
        .vld      (vld_vec),
        .any_free (any_free),
        .free_idx (free_idx)
    );

    logic             pin_full;
    logic             load_ok;
    logic             do_pin;
    logic             do_norm;
    logic [CNT_W-1:0] wr_slot;
    entry_t           new_ent;

    assign pin_full = (lock_base == FULL);
    assign load_ok  = is_load && !pin_full && (cmd_preserve || any_free);
    assign do_pin   = load_ok && cmd_preserve;
    assign do_norm  = load_ok && !cmd_preserve;
    assign wr_slot  = cmd_preserve ? lock_base : free_idx;
    assign new_ent  = make_entry(cmd_cam, cmd_ram);

    xlat_tlb_lock #(.NUM_ENTRIES(NUM_ENTRIES), .CNT_W(CNT_W)) u_lock (
        .clk          (clk),
        .rst          (rst),
        .do_flush_all (is_flush_all),
        .do_lock_wr   (is_lock_wr),
        .wr_base      (cmd_base),
        .wr_victim    (cmd_victim),
        .do_pin       (do_pin),
        .do_norm      (do_norm),
        .norm_slot    (free_idx),
        .base_q       (lock_base),
        .victim_q     (lock_victim)
    );

    // Entry storage
    always_ff @(posedge clk) begin
        if (rst) begin
            ent_q <= '0;
        end else if (is_flush_all) begin
            for (int i = 0; i < NUM_ENTRIES; i++) begin
                ent_q[i].vld <= 1'b0;
            end
        end else begin
            for (int i = 0; i < NUM_ENTRIES; i++) begin
                if (load_ok && (wr_slot == CNT_W'(i))) begin
                    ent_q[i] <= new_ent;
                end else if (is_flush_one && (lock_victim == CNT_W'(i))) begin
                    ent_q[i].vld <= 1'b0;
                end
            end
        end
    end

    // Read-back selection; victim equal to the entry count selects nothing
    entry_t rd_sel;
    always_comb begin
        rd_sel = '0;
        for (int i = 0; i < NUM_ENTRIES; i++) begin
            if (lock_victim == CNT_W'(i)) begin
                rd_sel = ent_q[i];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_busy <= 1'b0;
            rd_valid <= 1'b0;
            rd_cam   <= '0;
            rd_ram   <= '0;
        end else begin
            cmd_busy <= is_load && !load_ok;
            rd_valid <= is_read;
            if (is_read) begin
                rd_cam <= cam_word(rd_sel);
                rd_ram <= ram_word(rd_sel);
            end
        end
    end

    xlat_tlb_match #(.NUM_ENTRIES(NUM_ENTRIES)) u_match (
        .clk      (clk),
        .rst      (rst),
        .lk_valid (lk_valid),
        .lk_addr  (lk_addr),
        .ents     (ent_q),
        .lk_done  (lk_done),
        .lk_hit   (lk_hit),
        .lk_paddr (lk_paddr),
        .lk_size  (lk_size)
    );

endmodule

// File: rtl/xlat_tlb_chk.sv
module xlat_tlb_chk
    #(parameter int NUM_ENTRIES = 8,
      localparam int CNT_W      = $clog2(NUM_ENTRIES + 1))
    (
    input logic             clk,
    input logic             rst,
    input logic             cmd_valid,
    input logic [2:0]       cmd_op,
    input logic             cmd_preserve,
    input logic             cmd_busy,
    input logic             rd_valid,
    input logic [CNT_W-1:0] lock_base,
    input logic [CNT_W-1:0] lock_victim,
    input logic             lk_valid,
    input logic             lk_done,
    input logic             lk_hit,
    input logic [31:0]      lk_paddr,
    input logic [1:0]       lk_size
    );

    localparam logic [CNT_W-1:0] FULL = CNT_W'(NUM_ENTRIES);

    assert_lock_range_R9: assert property (@(posedge clk) disable iff (rst)
        (lock_base <= FULL) && (lock_victim <= FULL));

    assert_read_pulse_R9: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_op == 3'd3) |=> rd_valid);

    assert_gflush_R10: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_op == 3'd2) |=> (lock_base == '0) && (lock_victim == '0));

    assert_full_busy_R4: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_op == 3'd0 && lock_base == FULL) |=> cmd_busy);

    assert_busy_hold_R5: assert property (@(posedge clk) disable iff (rst)
        cmd_busy |-> ($stable(lock_base) && $stable(lock_victim)));

    assert_pin_step_R3: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_op == 3'd0 && cmd_preserve && lock_base != FULL)
        |=> (lock_base == CNT_W'($past(lock_base) + 1'b1)) && (lock_victim == lock_base));

    assert_norm_victim_R2: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_op == 3'd0 && !cmd_preserve)
        |=> cmd_busy || ((lock_victim < FULL) && (lock_base == $past(lock_base))));

    assert_lk_done_R7: assert property (@(posedge clk) disable iff (rst)
        lk_valid |=> lk_done);

    assert_lk_idle_R7: assert property (@(posedge clk) disable iff (rst)
        !lk_valid |=> !lk_done);

    assert_miss_zero_R7: assert property (@(posedge clk) disable iff (rst)
        (lk_done && !lk_hit) |-> (lk_paddr == '0) && (lk_size == '0));

endmodule

bind xlat_tlb xlat_tlb_chk #(.NUM_ENTRIES(NUM_ENTRIES)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .cmd_valid    (cmd_valid),
    .cmd_op       (cmd_op),
    .cmd_preserve (cmd_preserve),
    .cmd_busy     (cmd_busy),
    .rd_valid     (rd_valid),
    .lock_base    (lock_base),
    .lock_victim  (lock_victim),
    .lk_valid     (lk_valid),
    .lk_done      (lk_done),
    .lk_hit       (lk_hit),
    .lk_paddr     (lk_paddr),
    .lk_size      (lk_size)
);

// File: tb/test_xlat_tlb.sv
`timescale 1ns/1ps
module test_xlat_tlb;

    localparam int N  = 4;
    localparam int CW = $clog2(N + 1);

    logic          clk = 1'b0;
    logic          rst;
    logic          cmd_valid;
    logic [2:0]    cmd_op;
    logic [31:0]   cmd_cam;
    logic [31:0]   cmd_ram;
    logic          cmd_preserve;
    logic [CW-1:0] cmd_base;
    logic [CW-1:0] cmd_victim;
    logic          cmd_busy;
    logic          rd_valid;
    logic [31:0]   rd_cam;
    logic [31:0]   rd_ram;
    logic [CW-1:0] lock_base;
    logic [CW-1:0] lock_victim;
    logic          lk_valid;
    logic [31:0]   lk_addr;
    logic          lk_done;
    logic          lk_hit;
    logic [31:0]   lk_paddr;
    logic [1:0]    lk_size;

    always #2.5 clk = ~clk;

    xlat_tlb #(.NUM_ENTRIES(N)) i_xlat_tlb (
        .clk(clk), .rst(rst),
        .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_cam(cmd_cam), .cmd_ram(cmd_ram),
        .cmd_preserve(cmd_preserve), .cmd_base(cmd_base), .cmd_victim(cmd_victim),
        .cmd_busy(cmd_busy), .rd_valid(rd_valid), .rd_cam(rd_cam), .rd_ram(rd_ram),
        .lock_base(lock_base), .lock_victim(lock_victim),
        .lk_valid(lk_valid), .lk_addr(lk_addr), .lk_done(lk_done), .lk_hit(lk_hit),
        .lk_paddr(lk_paddr), .lk_size(lk_size)
    );

    int checks = 0;
    int fails  = 0;

    // Reference model of the array and lock register
    logic        m_vld [N];
    logic [19:0] m_tag [N];
    logic [1:0]  m_sz  [N];
    logic [19:0] m_pb  [N];
    logic [11:0] m_at  [N];
    int          m_base;
    int          m_vict;

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic int size_shift(logic [1:0] c);
        case (c)
            2'd0:    return 20;
            2'd1:    return 16;
            2'd2:    return 12;
            default: return 24;
        endcase
    endfunction

    task automatic issue(logic [2:0] op, logic [31:0] cam, logic [31:0] ram,
                         logic pres, int b, int v);
        @(negedge clk);
        cmd_valid    = 1'b1;
        cmd_op       = op;
        cmd_cam      = cam;
        cmd_ram      = ram;
        cmd_preserve = pres;
        cmd_base     = CW'(b);
        cmd_victim   = CW'(v);
        @(negedge clk);
        cmd_valid    = 1'b0;
    endtask

    task automatic check_lock(string req);
        chk(req, "lock_base", 32'(lock_base), 32'(m_base));
        chk(req, "lock_victim", 32'(lock_victim), 32'(m_vict));
    endtask

    task automatic t_load(string req, logic [31:0] va, logic [1:0] sz,
                          logic [19:0] pb, logic [11:0] at, logic pres);
        bit busy;
        int slot;
        slot = -1;
        for (int i = N - 1; i >= 0; i--) if (!m_vld[i]) slot = i;
        busy = (m_base == N) || (!pres && slot < 0);
        if (!busy) begin
            if (pres) slot = m_base;
            m_vld[slot] = 1'b1;
            m_tag[slot] = va[31:12];
            m_sz[slot]  = sz;
            m_pb[slot]  = pb;
            m_at[slot]  = at;
            if (pres) begin
                m_base = m_base + 1;
                m_vict = m_base;
            end else begin
                m_vict = (slot + 1 == N) ? m_base : slot + 1;
            end
        end
        issue(3'd0, {va[31:12], 10'h0, sz}, {pb, at}, pres, 0, 0);
        chk(req, "cmd_busy", 32'(cmd_busy), 32'(busy));
        check_lock(req);
    endtask

    task automatic t_lockwr(string req, int b, int v);
        m_base = (b > N) ? N : b;
        m_vict = (v > N) ? N : v;
        issue(3'd4, 0, 0, 1'b0, b, v);
        check_lock(req);
    endtask

    task automatic t_flush_one(string req);
        if (m_vict < N) m_vld[m_vict] = 1'b0;
        issue(3'd1, 0, 0, 1'b0, 0, 0);
        check_lock(req);
    endtask

    task automatic t_flush_all(string req);
        for (int i = 0; i < N; i++) m_vld[i] = 1'b0;
        m_base = 0;
        m_vict = 0;
        issue(3'd2, 0, 0, 1'b0, 0, 0);
        check_lock(req);
    endtask

    task automatic t_read(string req);
        logic [31:0] ec, er;
        ec = '0;
        er = '0;
        if (m_vict < N) begin
            ec = {m_tag[m_vict], 9'h0, m_vld[m_vict], m_sz[m_vict]};
            er = {m_pb[m_vict], m_at[m_vict]};
        end
        issue(3'd3, 0, 0, 1'b0, 0, 0);
        chk(req, "rd_valid", 32'(rd_valid), 32'd1);
        chk(req, "rd_cam", rd_cam, ec);
        chk(req, "rd_ram", rd_ram, er);
    endtask

    task automatic t_look(string req, logic [31:0] addr);
        bit          eh;
        logic [31:0] ep;
        logic [1:0]  es;
        eh = 1'b0;
        ep = '0;
        es = '0;
        for (int i = N - 1; i >= 0; i--) begin
            int sh;
            sh = size_shift(m_sz[i]);
            if (m_vld[i] && ((addr >> sh) == ({m_tag[i], 12'h0} >> sh))) begin
                eh = 1'b1;
                ep = ((({m_pb[i], 12'h0}) >> sh) << sh) | (addr & ((32'h1 << sh) - 32'h1));
                es = m_sz[i];
            end
        end
        @(negedge clk);
        lk_valid = 1'b1;
        lk_addr  = addr;
        @(negedge clk);
        lk_valid = 1'b0;
        chk(req, "lk_done", 32'(lk_done), 32'd1);
        chk(req, "lk_hit", 32'(lk_hit), 32'(eh));
        chk(req, "lk_paddr", lk_paddr, ep);
        chk(req, "lk_size", 32'(lk_size), 32'(es));
    endtask

    initial begin
        #500000;
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        rst = 1'b1;
        cmd_valid = 1'b0; cmd_op = '0; cmd_cam = '0; cmd_ram = '0;
        cmd_preserve = 1'b0; cmd_base = '0; cmd_victim = '0;
        lk_valid = 1'b0; lk_addr = '0;
        for (int i = 0; i < N; i++) begin
            m_vld[i] = 1'b0; m_tag[i] = '0; m_sz[i] = '0; m_pb[i] = '0; m_at[i] = '0;
        end
        m_base = 0;
        m_vict = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        check_lock("R1");
        chk("R1", "cmd_busy", 32'(cmd_busy), 32'd0);
        chk("R1", "rd_valid", 32'(rd_valid), 32'd0);
        chk("R1", "lk_done", 32'(lk_done), 32'd0);
        t_read("R1");
        t_look("R1", 32'h0000_0000);

        // R6: every size code against the edges of its region
        for (int c = 0; c < 4; c++) begin
            int          sh;
            logic [31:0] start, span;
            sh    = size_shift(2'(c));
            span  = 32'h1 << sh;
            start = 32'h5A00_0000 + (32'h3 << sh);
            t_flush_all("R6");
            t_load("R6", start, 2'(c), 20'h89ABC, 12'h5A5, 1'b0);
            t_read("R6");
            t_look("R6", start - 32'h1);
            t_look("R6", start);
            t_look("R6", start + (span >> 1) + 32'h123);
            t_look("R6", start + span - 32'h1);
            t_look("R6", start + span);
        end

        // R2 / R5: ordinary fill, then refusal when full
        t_flush_all("R10");
        for (int i = 0; i < N; i++) begin
            t_load("R2", 32'h1000_0000 + (32'(i) << 12), 2'd2, 20'h40000 + 20'(i), 12'(i), 1'b0);
        end
        t_load("R5", 32'h7000_0000, 2'd2, 20'h11111, 12'h0, 1'b0);
        t_look("R5", 32'h7000_0000);
        t_look("R2", 32'h1000_2ABC);
        // R5: pinned load still accepted on a full array (overwrites slot 0)
        t_load("R5", 32'h6000_0000, 2'd2, 20'h22222, 12'h3, 1'b1);
        t_look("R3", 32'h6000_0010);
        t_look("R3", 32'h1000_0010);

        // R8: flush the victim slot, then refill it
        t_lockwr("R9", 1, 2);
        t_flush_one("R8");
        t_look("R8", 32'h1000_2000);
        t_load("R2", 32'h3000_0000, 2'd2, 20'h33333, 12'h7, 1'b0);
        t_load("R5", 32'h3100_0000, 2'd2, 20'h33334, 12'h7, 1'b0);
        // R2: victim wraps to base, not to zero
        t_lockwr("R9", 1, 3);
        t_flush_one("R8");
        t_load("R2", 32'h3200_0000, 2'd2, 20'h44444, 12'h1, 1'b0);
        // R8 / R9: victim at entry count touches nothing
        t_lockwr("R9", 1, N);
        t_flush_one("R8");
        t_read("R9");
        for (int i = 0; i < N; i++) begin
            t_lockwr("R9", 1, i);
            t_read("R9");
        end
        // R9: clamping
        t_lockwr("R9", 7, 6);
        t_read("R9");
        // R4: fully pinned, every load refused
        t_load("R4", 32'h0AAA_0000, 2'd2, 20'h55555, 12'h0, 1'b1);
        t_load("R4", 32'h0AAA_0000, 2'd2, 20'h55555, 12'h0, 1'b0);
        t_look("R4", 32'h0AAA_0000);
        t_look("R4", 32'h3200_0FFF);

        // R3 / R4: pinned fill from empty
        t_flush_all("R10");
        t_look("R10", 32'h3200_0000);
        for (int i = 0; i < N; i++) begin
            t_load("R3", 32'h0800_0000 + (32'(i) << 20), 2'd0, 20'h0A000 + (20'(i) << 8), 12'h0, 1'b1);
        end
        t_load("R4", 32'h0F00_0000, 2'd0, 20'h0, 12'h0, 1'b1);
        t_look("R3", 32'h0830_0040);

        // R7: overlapping entries, lowest index wins
        t_flush_all("R10");
        t_load("R7", 32'h2000_0000, 2'd3, 20'h30000, 12'h0, 1'b0);
        t_load("R7", 32'h2034_5000, 2'd2, 20'h77777, 12'h0, 1'b0);
        t_look("R7", 32'h2034_5678);
        t_lockwr("R9", 0, 0);
        t_flush_one("R8");
        t_look("R7", 32'h2034_5678);
        t_look("R7", 32'h2034_6678);

        // R7: no request, no result
        @(negedge clk);
        chk("R7", "lk_done idle", 32'(lk_done), 32'd0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule